// File: doc/BRIEF.md
# Periodic Ping Synchronization Controller

This block keeps a sample capture schedule aligned to an acoustic beacon that sounds at a fixed, known interval. It watches the multichannel sample stream, compares each sample's magnitude against a programmable level, and decides which samples a downstream capture path should keep. It does this through its capture-enable output. Time comes from an external free-running timestamp counter, so the schedule is tied to the same time base as the stored samples.

After reset the controller hunts for the beacon. It keeps a continuous search window that is slightly longer than one beacon interval and notes the timestamp of the earliest over-level sample in it. From that timestamp it predicts the next arrival and opens a short tracking window centred on the prediction. Every tracking window that holds an arrival refreshes the prediction and keeps the lock. An empty tracking window drops the controller back into searching. A debug input makes it run back-to-back search windows and never lock. Durations are counted in valid sample ticks, and the defaults assume a 5 MHz sample rate with a two-second beacon.

Top module: `ping_sync_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after release, the controller is searching: capture_en is 1, locked is 0 and ping_valid is 0.
- R2: A sample counts as a crossing when the absolute value of any channel, read as signed two's complement, is greater than or equal to the unsigned threshold. A magnitude one below the threshold does not count.
- R3: A search window spans SEARCH_TICKS valid samples with capture_en held high throughout. The reported timestamp is that of the earliest crossing in the window. A window with no crossing is followed at once by another search window.
- R4: When a window ends holding a crossing, ping_valid is 1 for exactly one cycle, the cycle after the window's last sample. In that cycle ping_ts holds the crossing timestamp and locked is 1.
- R5: The predicted arrival is ping_ts + PERIOD_TICKS. The tracking window opens at the first cycle whose timestamp equals or passes the prediction minus TRACK_TICKS/2. If that opening time is not already in the future when the report is made, the prediction moves forward by PERIOD_TICKS, one step per cycle, until it is.
- R6: A tracking window spans TRACK_TICKS valid samples. While locked, capture_en is 0 outside tracking windows, including the cycle of each report.
- R7: A tracking window that holds a crossing reports the timestamp of its earliest crossing as in R4, and locked stays 1.
- R8: A tracking window with no crossing clears locked in the cycle after its last sample, and a search window begins in that same cycle.
- R9: While debug_mode is 1 the controller only searches. In the cycle after debug_mode is seen, locked is 0 and capture_en is 1, and no report is made.
- R10: All timestamp arithmetic and comparisons wrap modulo 2^TS_W, so a window may straddle the timestamp rollover.
- R11: A cycle with sample_valid low neither advances a window nor counts as a crossing, so a window stretches by one cycle for each such gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_valid | input | 1 | The sample word is valid in this cycle |
| samples | input | NUM_CH*SAMPLE_W | Signed samples, channel i in bits [i*SAMPLE_W +: SAMPLE_W] |
| threshold | input | SAMPLE_W | Unsigned crossing level |
| timestamp | input | TS_W | Free-running sample-tick time base |
| debug_mode | input | 1 | Search continuously, never lock |
| capture_en | output | 1 | The current sample belongs to a capture window |
| ping_valid | output | 1 | One-cycle report strobe |
| ping_ts | output | TS_W | Timestamp of the last reported arrival |
| locked | output | 1 | Tracking mode |

## Verification
The bound checker watches rules that hold in every cycle. Capture is on whenever the controller is not locked. A report is a lone one-cycle pulse made while locked, and capture is off during it. ping_ts changes only with a report. A loss of lock is followed at once by capture, and debug mode clears lock and suppresses reports. Other behaviours cannot be seen in a single cycle and need the bench's scenarios with a small period: the exact cycle each tracking window opens, window lengths, the choice of the earliest crossing, threshold equality, the forward step of an already passed prediction, rollover of the timestamp, and stretching over invalid samples.

// File: rtl/ping_sync_pkg.sv
package ping_sync_pkg;

  // Controller phases: hunting, computing the next opening, waiting, and
  // capturing a short window around the predicted arrival.
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_PLAN   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_TRACK  = 2'd3
  } sync_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ping_detect.sv
module ping_detect #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]        threshold,
  output logic                       hit
);

  logic [NUM_CH-1:0] over;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [SAMPLE_W-1:0] raw;
      logic [SAMPLE_W-1:0] mag;
      assign raw  = samples[c*SAMPLE_W +: SAMPLE_W];
      // Two's-complement magnitude; the most negative code maps to 2^(W-1).
      assign mag  = raw[SAMPLE_W-1] ? (~raw + SAMPLE_W'(1)) : raw;
      assign over[c] = (mag >= threshold);
    end
  endgenerate

  assign hit = |over;

endmodule

// File: rtl/ping_window_ctr.sv
module ping_window_ctr #(
  parameter int unsigned LONG_LEN  = 10_500_000,
  parameter int unsigned SHORT_LEN = 1_250_000,
  localparam int unsigned MAX_LEN  = ping_sync_pkg::max_u(LONG_LEN, SHORT_LEN),
  localparam int unsigned CNT_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic use_long,
  output logic last
);

  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign last = (cnt_q == (use_long ? LONG_END : SHORT_END));

  always_comb begin
    cnt_en = clear | tick;
    if (clear)     cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ping_first_hit.sv
module ping_first_hit #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            hit,
  input  logic            clear,
  input  logic [TS_W-1:0] timestamp,
  output logic            found_now,
  output logic [TS_W-1:0] first_ts
);

  logic            found_q;
  logic [TS_W-1:0] hit_ts_q;
  logic            take;

  // Only the first crossing of a window is kept.
  assign take      = tick & hit & ~found_q;
  assign found_now = found_q | (tick & hit);
  assign first_ts  = found_q ? hit_ts_q : timestamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     found_q <= 1'b0;
    else if (clear) found_q <= 1'b0;
    else if (take)  found_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hit_ts_q <= '0;
    else if (take && !clear)    hit_ts_q <= timestamp;
  end

endmodule

// File: rtl/ping_predictor.sv
module ping_predictor #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned PERIOD = 10_000_000,
  parameter int unsigned HALF   = 625_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TS_W-1:0] load_ts,
  input  logic            advance,
  input  logic [TS_W-1:0] timestamp,
  output logic            open_due
);

  localparam logic [TS_W-1:0] PERIOD_C = TS_W'(PERIOD);
  localparam logic [TS_W-1:0] HALF_C   = TS_W'(HALF);

  logic [TS_W-1:0] pred_q;
  logic [TS_W-1:0] pred_d;
  logic            pred_en;
  logic [TS_W-1:0] open_ts;
  logic [TS_W-1:0] lead;

  assign pred_en = load | advance;
  assign pred_d  = (load ? load_ts : pred_q) + PERIOD_C;

  // Modular difference: a non-negative result means the opening time has
  // been reached or passed, even across a rollover.
  assign open_ts  = pred_q - HALF_C;
  assign lead     = timestamp - open_ts;
  assign open_due = ~lead[TS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pred_q <= '0;
    else if (pred_en) pred_q <= pred_d;
  end

endmodule

// File: rtl/ping_sync_ctrl.sv
module ping_sync_ctrl #(
  parameter int unsigned NUM_CH       = 4,
  parameter int unsigned SAMPLE_W     = 14,
  parameter int unsigned TS_W         = 32,
  parameter int unsigned PERIOD_TICKS = 10_000_000,
  parameter int unsigned SEARCH_TICKS = 10_500_000,
  parameter int unsigned TRACK_TICKS  = 1_250_000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic [SAMPLE_W-1:0]        threshold,
  input  logic [TS_W-1:0]            timestamp,
  input  logic                       debug_mode,
  output logic                       capture_en,
  output logic                       ping_valid,
  output logic [TS_W-1:0]            ping_ts,
  output logic                       locked
);

  import ping_sync_pkg::*;

  localparam int unsigned HALF_TICKS = TRACK_TICKS / 2;

  sync_state_e     st_q;
  sync_state_e     st_d;
  logic            hit;
  logic            last;
  logic            open_due;
  logic            found_now;
  logic [TS_W-1:0] first_ts;
  logic            abort;
  logic            win_active;
  logic            tick;
  logic            win_end;
  logic            report;
  logic            lost;
  logic            advance;
  logic            lock_en;

  ping_detect #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W)
  ) u_detect (
    .samples   (samples),
    .threshold (threshold),
    .hit       (hit)
  );

  ping_window_ctr #(
    .LONG_LEN  (SEARCH_TICKS),
    .SHORT_LEN (TRACK_TICKS)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clear    (abort),
    .use_long (st_q == ST_SEARCH),
    .last     (last)
  );

  ping_first_hit #(
    .TS_W (TS_W)
  ) u_first (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hit       (hit),
    .clear     (win_end | abort),
    .timestamp (timestamp),
    .found_now (found_now),
    .first_ts  (first_ts)
  );

  ping_predictor #(
    .TS_W   (TS_W),
    .PERIOD (PERIOD_TICKS),
    .HALF   (HALF_TICKS)
  ) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (report),
    .load_ts   (first_ts),
    .advance   (advance),
    .timestamp (timestamp),
    .open_due  (open_due)
  );

  // Debug mode pulls every non-search phase straight back to searching.
  assign abort      = debug_mode & (st_q != ST_SEARCH);
  assign win_active = ~abort & ((st_q == ST_SEARCH) | (st_q == ST_TRACK) |
                                ((st_q == ST_WAIT) & open_due));
  assign tick       = win_active & sample_valid;
  assign win_end    = tick & last;
  assign capture_en = win_active;

  always_comb begin
    st_d    = st_q;
    report  = 1'b0;
    lost    = 1'b0;
    advance = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (win_end && found_now && !debug_mode) begin
          report = 1'b1;
          st_d   = ST_PLAN;
        end
      end
      ST_PLAN: begin
        if (abort)         st_d    = ST_SEARCH;
        else if (open_due) advance = 1'b1;
        else               st_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (abort)     st_d = ST_SEARCH;
        else if (tick) st_d = ST_TRACK;
      end
      ST_TRACK: begin
        if (abort) begin
          st_d = ST_SEARCH;
        end else if (win_end) begin
          if (found_now) begin
            report = 1'b1;
            st_d   = ST_PLAN;
          end else begin
            lost = 1'b1;
            st_d = ST_SEARCH;
          end
        end
      end
      default: st_d = ST_SEARCH;
    endcase
  end

  assign lock_en = report | lost | abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SEARCH;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b0;
    else if (lock_en) locked <= report;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ping_valid <= 1'b0;
    else        ping_valid <= report;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ping_ts <= '0;
    else if (report) ping_ts <= first_ts;
  end

endmodule

// File: rtl/ping_sync_checker.sv
module ping_sync_checker #(
  parameter int unsigned TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            debug_mode,
  input logic            capture_en,
  input logic            ping_valid,
  input logic [TS_W-1:0] ping_ts,
  input logic            locked
);

  // R3
  unlocked_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> capture_en);

  // R4
  report_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_valid |-> locked);

  // R4
  report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_valid |=> !ping_valid);

  // R6
  report_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_valid |-> !capture_en);

  // R7
  ts_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ping_ts != $past(ping_ts)) |-> ping_valid);

  // R8
  loss_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> capture_en);

  // R9
  debug_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |=> (!locked && !ping_valid));

endmodule

bind ping_sync_ctrl ping_sync_checker #(.TS_W(TS_W)) u_sync_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .debug_mode (debug_mode),
  .capture_en (capture_en),
  .ping_valid (ping_valid),
  .ping_ts    (ping_ts),
  .locked     (locked)
);

// File: tb/test_ping_sync_ctrl.sv
`timescale 1ns/1ps
module test_ping_sync_ctrl;

  localparam int NCH  = 2;
  localparam int SW   = 8;
  localparam int TSW  = 32;
  localparam int P    = 100;
  localparam int S    = 110;
  localparam int T    = 20;
  localparam int H    = T / 2;
  localparam int THR  = 50;
  localparam logic [31:0] BASE = 32'hFFFF_FF60;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                sample_valid;
  logic [NCH*SW-1:0]   samples;
  logic [SW-1:0]       threshold;
  logic [TSW-1:0]      timestamp;
  logic                debug_mode;
  logic                capture_en;
  logic                ping_valid;
  logic [TSW-1:0]      ping_ts;
  logic                locked;

  always #2 clk = ~clk;

  ping_sync_ctrl #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .TS_W(TSW),
    .PERIOD_TICKS(P), .SEARCH_TICKS(S), .TRACK_TICKS(T)
  ) i_ping_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .samples(samples),
    .threshold(threshold), .timestamp(timestamp), .debug_mode(debug_mode),
    .capture_en(capture_en), .ping_valid(ping_valid), .ping_ts(ping_ts),
    .locked(locked)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;
  int n     = 0;
  int cur   = 0;

  // Beacon model: source A on channel 0 (+60), source B on channel 1 (-THR).
  int pa = 5, pa_end = 1 << 30, pb = 1 << 30;
  int dec_n = -1, dec_c = 0, dec_v = 0;
  int gap_lo = -5, gap_hi = -5;

  function automatic int ch_val(int k, int c);
    int v;
    v = (c == 0) ? (k % 7) : -(k % 5);
    if (c == 0 && k >= pa && k < pa_end && ((k - pa) % P) < 3) v = 60;
    if (c == 1 && k >= pb && ((k - pb) % P) < 3) v = -THR;
    if (k == dec_n && c == dec_c) v = dec_v;
    return v;
  endfunction

  function automatic int peak_mag(int k);
    int a, b;
    a = ch_val(k, 0); b = ch_val(k, 1);
    if (a < 0) a = -a;
    if (b < 0) b = -b;
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (n=%0d)", tag, act, exp, cur);
    end
  endtask

  task automatic step();
    @(negedge clk);
    timestamp    = BASE + 32'(n);
    sample_valid = !(n >= gap_lo && n <= gap_hi);
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'(ch_val(n, c));
    #1;
    cur = n;
    n++;
  endtask

  task automatic wait_cap(int lim);
    int g = 0;
    do begin step(); g++; end while (!capture_en && g < lim);
  endtask

  task automatic wait_report(int lim);
    int g = 0;
    do begin step(); g++; end while (!ping_valid && g < lim);
  endtask

  // Walk one tracking window; returns number of cycles capture_en was high.
  task automatic run_track(output int len);
    len = 0;
    while (capture_en && len < 1000) begin len++; step(); end
  endtask

  function automatic int next_open(int ping_n, int now);
    int o;
    o = ping_n + P - H;
    while (o <= now) o += P;
    return o;
  endfunction

  initial begin
    int exp_open, len, ping_n, s0, bad;
    rst_n = 1'b0; debug_mode = 1'b0; threshold = SW'(THR);
    sample_valid = 1'b0; samples = '0; timestamp = '0;
    repeat (4) @(negedge clk);
    #1;
    chk(capture_en == 1 && locked == 0 && ping_valid == 0, "R1 reset", locked, 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    // First cycle after release: sample n=0 is driven and observed.
    timestamp = BASE; sample_valid = 1'b1;
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'(ch_val(0, c));
    #1; cur = 0; n = 1;
    chk(capture_en == 1, "R1 capture after release", capture_en, 1);
    chk(locked == 0 && ping_valid == 0, "R1 idle outputs", locked, 0);

    // Search over n=0..109 holds arrivals at 5 and 105: earliest is 5.
    wait_report(300);
    chk(cur == S, "R4 report cycle", cur, S);
    chk(ping_ts == BASE + 32'(5), "R3 earliest crossing", ping_ts, BASE + 32'(5));
    chk(locked == 1, "R4 locked", locked, 1);
    ping_n = 5;
    // Opening 95 already passed at n=110: moves forward one period.
    exp_open = next_open(ping_n, cur);
    chk(exp_open == 195, "R5 forward step", exp_open, 195);

    for (int k = 0; k < 3; k++) begin
      if (k == 2) begin
        gap_lo = exp_open + 2; gap_hi = exp_open + 6;
        dec_n = exp_open + 3; dec_c = 0; dec_v = 100;
      end
      wait_cap(400);
      chk(cur == exp_open, "R5 window opening", cur, exp_open);
      run_track(len);
      if (k == 2) chk(len == T + 5, "R11 stretched window", len, T + 5);
      else        chk(len == T, "R6 track length", len, T);
      chk(ping_valid == 1, "R7 report after track", ping_valid, 1);
      chk(ping_ts == BASE + 32'(exp_open + H), "R7 R10 tracked timestamp",
          ping_ts, BASE + 32'(exp_open + H));
      chk(locked == 1, "R7 stays locked", locked, 1);
      ping_n = exp_open + H;
      exp_open = next_open(ping_n, cur);
    end

    // Source A falls silent: next tracking window is empty.
    pa_end = cur;
    wait_cap(400);
    chk(cur == exp_open, "R5 empty window opening", cur, exp_open);
    while (cur < exp_open + T - 1) step();
    chk(locked == 1, "R8 locked through window", locked, 1);
    s0 = exp_open + T;
    pb = s0 + 40; dec_n = s0 + 10; dec_c = 0; dec_v = THR - 1;
    step();
    chk(locked == 0, "R8 lock dropped", locked, 0);
    chk(capture_en == 1, "R8 search begins", capture_en, 1);

    wait_report(400);
    chk(cur == s0 + S, "R3 search length", cur, s0 + S);
    chk(ping_ts == BASE + 32'(pb), "R2 negative at threshold, below ignored",
        ping_ts, BASE + 32'(pb));
    exp_open = next_open(pb, cur);
    wait_cap(400);
    chk(cur == exp_open, "R5 reacquired opening", cur, exp_open);
    run_track(len);
    chk(ping_ts == BASE + 32'(pb + P), "R7 reacquired track", ping_ts, BASE + 32'(pb + P));

    // Debug mode while locked.
    debug_mode = 1'b1;
    step();
    step();
    chk(locked == 0 && capture_en == 1, "R9 debug unlock", locked, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (ping_valid || locked || !capture_en) bad++;
    end
    chk(bad == 0, "R9 debug search only", bad, 0);
    debug_mode = 1'b0;
    wait_report(400);
    ping_n = int'(ping_ts - BASE);
    chk(ping_valid == 1 && locked == 1, "R4 relock after debug", locked, 1);
    chk(peak_mag(ping_n) >= THR, "R2 reported sample crosses", peak_mag(ping_n), THR);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule